// File: doc/BRIEF.md
# Display Controller Enable Sequencer and Pin Ownership Mux

This block holds the control word of a passive-panel display controller and decides, cycle by cycle, whether the controller is running and which pads it drives. Software sets the enable bit, the colour/monochrome select, the single/dual-panel select, a four/eight-pin monochrome width bit, an active-panel bit and an interrupt enable. All of these are written together in one word. A two-state sequencer starts a frame at line 0 as soon as enable is seen. It then counts lines from a line-done strobe supplied by the timing generator. It advances one line per strobe for a single panel and two lines per strobe for a dual passive panel.

Clearing enable does not stop the controller at once. The frame in flight completes under the mode fields that were in force before the clearing write. Only then does the block go idle. At that point it raises a sticky, write-one-to-clear disable-done flag, and the flag drives an interrupt when the interrupt enable is set.

A pin mux owns twelve controller pads: eight low data pins and four control pins. It also owns eight upper data pads borrowed from general-purpose pins 2 to 9. A pad that the current mode does not use is left to the general-purpose path. When the controller is idle, every pad is left to that path.

Top module: `dispctl_top`

## Requirements
- R1: After reset the control word reads 0, `running`, `done_flag` and `irq` are 0, `line_idx` is 0, and no pad is owned by the controller.
- R2: While `running` is 0, `own_lcd` and `own_hi` are all zero, and every pad output equals its general-purpose source.
- R3: A control write with bit 0 (enable) set, made while idle, makes `running` 1 one clock later, with `line_idx` at 0.
- R4: While running, each `line_done` pulse advances `line_idx` by 2 in dual passive mode and by 1 otherwise. `frame_end` is high during the pulse that completes `LINES` lines, and the next frame starts at line 0.
- R5: If enable is cleared while running, `running` stays 1 until the `frame_end` pulse that ends the current frame, and becomes 0 on the following clock. `done_flag` is set on that same clock.
- R6: A control write with enable clear, made while running, leaves the latched mode, and so `n_data` and pad ownership, unchanged. A write made while idle, or any write with enable set, loads the mode.
- R7: A status write (`wr_sel`=1) with bit 0 set clears `done_flag`; a status write with bit 0 clear leaves it unchanged. If a set and a clear fall on the same clock, the set wins.
- R8: `irq` is high exactly when `done_flag` is 1 and control bit 4 (interrupt enable) is 1.
- R9: Control bit 1 selects monochrome, bit 2 selects dual panel, bit 3 selects the 8-pin monochrome width, and bit 5 selects an active (non-passive) panel. `n_data` is 8 for colour single, 16 for colour dual, 4 or 8 (by bit 3) for monochrome single, and 8 for monochrome dual.
- R10: While running, the controller owns `pad_lcd` bits [11:8] (control), `pad_lcd` bits [n-1:0] of the low eight data pins, and all eight `pad_hi` pins only when `n_data` is 16. Each owned pad carries the controller source.
- R11: With control bit 5 set, the dual-panel bit is ignored: the line step is 1 and the pin count is the single-panel value.
- R12: Writing enable back to 1 before the draining frame ends cancels the shutdown, so the controller keeps running and `done_flag` is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control word, 1 = status (write-one-to-clear) |
| wr_data | input | 6 | Write data |
| line_done | input | 1 | One-cycle strobe at the end of each transmitted line slot |
| ctl_lcd | input | 12 | Controller drive for its own pads |
| ctl_hi | input | 8 | Controller drive for the upper data pads |
| gpio_lcd | input | 12 | General-purpose drive for the controller pads |
| gpio_hi | input | 8 | General-purpose drive for the upper data pads |
| pad_lcd | output | 12 | Controller pads after ownership mux |
| pad_hi | output | 8 | Upper data pads (GP pins 2..9) after mux |
| own_lcd | output | 12 | 1 = controller owns that pad |
| own_hi | output | 8 | 1 = controller owns that upper pad |
| ctrl_q | output | 6 | Control word readback |
| done_flag | output | 1 | Disable-done status flag |
| irq | output | 1 | Disable-done interrupt request |
| running | output | 1 | Controller active |
| frame_end | output | 1 | High during the line strobe that ends a frame |
| line_idx | output | LW | Current line index |
| n_data | output | 5 | Number of active data pins in the latched mode |

## Verification
The assertions assume that `line_done` is a single-cycle strobe. They also assume that `LINES` is even and at least 2, so that a dual-panel step of two lines lands exactly on the frame boundary. Neither property is checked inside the block. The stimulus raises `line_done` for one cycle with at least one low cycle between pulses, and it builds the design with six lines per frame. Register writes are also one-cycle strobes, applied between clock edges. The bench never leaves a strobe high across two edges.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

  typedef struct packed {
    logic act;
    logic wide;
    logic dual;
    logic mono;
  } mode_t;

  localparam int CTRL_W = 6;

  function automatic logic [4:0] data_pins(mode_t m);
    logic two;
    two = m.dual && !m.act;
    if (!m.mono) return two ? 5'd16 : 5'd8;
    if (two) return 5'd8;
    return m.wide ? 5'd8 : 5'd4;
  endfunction

endpackage

// File: rtl/dispctl_regs.sv
module dispctl_regs
  import dispctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              running,
  input  logic              set_done,
  output logic [CTRL_W-1:0] ctrl_q,
  output mode_t             mode_act,
  output logic              done_flag,
  output logic              irq
);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && !wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      mode_act <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= wr_data;
      // a disabling write during a frame must not disturb the live mode
      if (!running || wr_data[0])
        mode_act <= '{act: wr_data[5], wide: wr_data[3],
                      dual: wr_data[2], mono: wr_data[1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      done_flag <= 1'b0;
    else if (set_done)
      done_flag <= 1'b1;
    else if (wr_en && wr_sel && wr_data[0])
      done_flag <= 1'b0;
  end

  assign irq = done_flag && ctrl_q[4];

endmodule

// File: rtl/dispctl_frame_fsm.sv
module dispctl_frame_fsm #(
  parameter int LINES = 480,
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          step2,
  input  logic          line_done,
  output logic          running,
  output logic          frame_end,
  output logic          set_done,
  output logic [LW-1:0] line_idx
);

  localparam logic [LW:0] LINES_C = (LW+1)'(LINES);

  logic [LW:0] nxt;
  logic        last;

  assign nxt       = {1'b0, line_idx} + (step2 ? (LW+1)'(2) : (LW+1)'(1));
  assign last      = nxt >= LINES_C;
  assign frame_end = running && line_done && last;
  assign set_done  = frame_end && !en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      line_idx <= '0;
    end else if (!running) begin
      line_idx <= '0;
      if (en) running <= 1'b1;
    end else if (line_done) begin
      line_idx <= last ? '0 : nxt[LW-1:0];
      if (last && !en) running <= 1'b0;
    end
  end

endmodule

// File: rtl/dispctl_pin_mux.sv
module dispctl_pin_mux #(
  parameter int NLO  = 8,
  parameter int NCTL = 4,
  parameter int NHI  = 8,
  localparam int NLCD = NLO + NCTL
) (
  input  logic            running,
  input  logic [4:0]      n_data,
  input  logic [NLCD-1:0] ctl_lcd,
  input  logic [NHI-1:0]  ctl_hi,
  input  logic [NLCD-1:0] gpio_lcd,
  input  logic [NHI-1:0]  gpio_hi,
  output logic [NLCD-1:0] own_lcd,
  output logic [NHI-1:0]  own_hi,
  output logic [NLCD-1:0] pad_lcd,
  output logic [NHI-1:0]  pad_hi
);

  localparam logic [4:0] WIDE_N = 5'(NLO + NHI);

  for (genvar i = 0; i < NLCD; i++) begin : g_lcd
    if (i < NLO) begin : g_data
      assign own_lcd[i] = running && (n_data > 5'(i));
    end else begin : g_ctl
      assign own_lcd[i] = running;
    end
    assign pad_lcd[i] = own_lcd[i] ? ctl_lcd[i] : gpio_lcd[i];
  end

  for (genvar j = 0; j < NHI; j++) begin : g_hi
    assign own_hi[j] = running && (n_data == WIDE_N);
    assign pad_hi[j] = own_hi[j] ? ctl_hi[j] : gpio_hi[j];
  end

endmodule

// File: rtl/dispctl_top.sv
module dispctl_top
  import dispctl_pkg::*;
#(
  parameter int LINES = 480,
  parameter int NCTL  = 4,
  localparam int NLO  = 8,
  localparam int NHI  = 8,
  localparam int NLCD = NLO + NCTL,
  localparam int LW   = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              line_done,
  input  logic [NLCD-1:0]   ctl_lcd,
  input  logic [NHI-1:0]    ctl_hi,
  input  logic [NLCD-1:0]   gpio_lcd,
  input  logic [NHI-1:0]    gpio_hi,
  output logic [NLCD-1:0]   pad_lcd,
  output logic [NHI-1:0]    pad_hi,
  output logic [NLCD-1:0]   own_lcd,
  output logic [NHI-1:0]    own_hi,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              done_flag,
  output logic              irq,
  output logic              running,
  output logic              frame_end,
  output logic [LW-1:0]     line_idx,
  output logic [4:0]        n_data
);

  mode_t mode_act;
  logic  set_done;

  dispctl_regs regs_i (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data,
    .running, .set_done, .ctrl_q, .mode_act, .done_flag, .irq
  );

  dispctl_frame_fsm #(.LINES(LINES)) fsm_i (
    .clk, .rst_n,
    .en        (ctrl_q[0]),
    .step2     (mode_act.dual && !mode_act.act),
    .line_done,
    .running, .frame_end, .set_done, .line_idx
  );

  assign n_data = data_pins(mode_act);

  dispctl_pin_mux #(.NLO(NLO), .NCTL(NCTL), .NHI(NHI)) mux_i (
    .running, .n_data, .ctl_lcd, .ctl_hi, .gpio_lcd, .gpio_hi,
    .own_lcd, .own_hi, .pad_lcd, .pad_hi
  );

endmodule

// File: rtl/dispctl_checker.sv
module dispctl_checker #(
  parameter int LINES = 480,
  parameter int NLCD  = 12,
  parameter int NHI   = 8,
  parameter int LW    = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            running,
  input logic            frame_end,
  input logic            done_flag,
  input logic            irq,
  input logic [NLCD-1:0] own_lcd,
  input logic [NHI-1:0]  own_hi,
  input logic [5:0]      ctrl_q,
  input logic [LW-1:0]   line_idx,
  input logic [4:0]      n_data
);

  assert_idle_gpio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (own_lcd == '0 && own_hi == '0));

  assert_start_line0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> line_idx == '0);

  assert_line_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(line_idx) < LINES);

  assert_stop_on_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> ($past(frame_end) && done_flag));

  assert_mode_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !ctrl_q[0] && $past(running && !ctrl_q[0])) |-> $stable(n_data));

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag);

  assert_hi_only_wide_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (own_hi != '0) |-> n_data == 5'd16);

endmodule

bind dispctl_top dispctl_checker #(.LINES(LINES), .NLCD(NLCD), .NHI(NHI), .LW(LW)) chk_i (
  .clk, .rst_n, .running, .frame_end, .done_flag, .irq,
  .own_lcd, .own_hi, .ctrl_q, .line_idx, .n_data
);

// File: tb/dispctl_top_tb_top.sv
`timescale 1ns/1ps
module dispctl_top_tb_top;

  localparam int LINES = 6;
  localparam int LW = $clog2(LINES);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sel = 0, line_done = 0;
  logic [5:0] wr_data = '0;
  logic [11:0] ctl_lcd = 12'hA5C, gpio_lcd = 12'h5A3;
  logic [7:0]  ctl_hi = 8'h3C, gpio_hi = 8'hC3;
  logic [11:0] pad_lcd, own_lcd;
  logic [7:0]  pad_hi, own_hi;
  logic [5:0]  ctrl_q;
  logic done_flag, irq, running, frame_end;
  logic [LW-1:0] line_idx;
  logic [4:0] n_data;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dispctl_top #(.LINES(LINES)) dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [5:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_sel = 0; wr_data = '0;
  endtask

  task automatic pulse(output logic fe);
    @(negedge clk);
    line_done = 1;
    #1 fe = frame_end;
    @(negedge clk);
    line_done = 0;
  endtask

  function automatic int exp_pins(bit mono, bit dual, bit wide, bit act);
    bit two = dual && !act;
    if (!mono) return two ? 16 : 8;
    if (two) return 8;
    return wide ? 8 : 4;
  endfunction

  task automatic chk_pads(input string req, input bit run, input int n);
    logic [11:0] ol;
    logic [7:0]  oh;
    ol = run ? {4'hF, (n >= 8) ? 8'hFF : 8'h0F} : 12'h0;
    oh = (run && n == 16) ? 8'hFF : 8'h00;
    chk({req, " own_lcd"}, int'(own_lcd), int'(ol));
    chk({req, " own_hi"}, int'(own_hi), int'(oh));
    chk({req, " pad_lcd"}, int'(pad_lcd), int'((ctl_lcd & ol) | (gpio_lcd & ~ol)));
    chk({req, " pad_hi"}, int'(pad_hi), int'((ctl_hi & oh) | (gpio_hi & ~oh)));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic fe;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state, R2 idle pads
    chk("R1 ctrl_q", ctrl_q, 0);
    chk("R1 running", running, 0);
    chk("R1 done_flag", done_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 line_idx", line_idx, 0);
    chk_pads("R2 idle", 0, 0);

    // sweep all mode combinations: bit1 mono, bit2 dual, bit3 wide, bit5 active
    for (int m = 0; m < 16; m++) begin
      bit mono = m[0], dual = m[1], wide = m[2], act = m[3];
      int n = exp_pins(mono, dual, wide, act);
      int per = (dual && !act) ? LINES / 2 : LINES;
      wr(0, {act, 1'b1, wide, dual, mono, 1'b1});
      @(negedge clk);
      chk("R3 running", running, 1);
      chk("R3 line0", line_idx, 0);
      chk("R9 R11 n_data", n_data, n);
      chk_pads("R10 run", 1, n);
      for (int k = 0; k < per; k++) begin
        pulse(fe);
        chk("R4 frame_end", fe, (k == per - 1) ? 1 : 0);
        chk("R4 line_idx", line_idx, (k == per - 1) ? 0 : (k + 1) * ((dual && !act) ? 2 : 1));
      end
      pulse(fe);
      // disable mid-frame and try to change the mode
      wr(0, {act, 1'b1, ~wide, ~dual, ~mono, 1'b0});
      chk("R5 still running", running, 1);
      chk("R6 n_data frozen", n_data, n);
      chk_pads("R6 frozen pads", 1, n);
      for (int k = 1; k < per; k++) begin
        chk("R5 before end", running, 1);
        pulse(fe);
        chk("R5 frame_end", fe, (k == per - 1) ? 1 : 0);
      end
      chk("R5 stopped", running, 0);
      chk("R5 flag", done_flag, 1);
      chk("R8 irq", irq, 1);
      chk_pads("R2 after stop", 0, n);
      wr(1, 6'd0);
      chk("R7 write 0 keeps", done_flag, 1);
      wr(1, 6'd1);
      chk("R7 w1c", done_flag, 0);
      chk("R8 irq low", irq, 0);
    end

    // R8 mask: flag set with interrupt enable clear
    wr(0, 6'b000001);
    @(negedge clk);
    for (int k = 0; k < LINES; k++) pulse(fe);
    wr(0, 6'b000000);
    for (int k = 0; k < LINES; k++) pulse(fe);
    chk("R8 flag masked", done_flag, 1);
    chk("R8 irq masked", irq, 0);
    wr(1, 6'd1);

    // R12 cancel shutdown by re-enabling mid-frame
    wr(0, 6'b010001);
    @(negedge clk);
    pulse(fe); pulse(fe);
    wr(0, 6'b010000);
    wr(0, 6'b010001);
    for (int k = 2; k < LINES; k++) pulse(fe);
    chk("R12 frame_end", fe, 1);
    chk("R12 running", running, 1);
    chk("R12 no flag", done_flag, 0);

    // R7 set wins over simultaneous clear; flag cleared first then reset
    wr(0, 6'b010000);
    for (int k = 1; k < LINES; k++) pulse(fe);
    @(negedge clk);
    line_done = 1; wr_en = 1; wr_sel = 1; wr_data = 6'd1;
    @(negedge clk);
    line_done = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
    chk("R7 set wins", done_flag, 1);
    chk("R7 stopped", running, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule